// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block is a memory-mapped event timer. A 64-bit up-counter advances by one on each clock while a run bit is set. Several comparator channels watch the low 32 bits of that counter. A channel can fire once and then leave its comparator alone. A channel that supports periodic operation can instead add a stored period to its comparator on every match. Software reaches every register through a simple 32-bit register port, with writes taking effect at once and reads returning one cycle later.

Each channel can deliver its event in one of three ways:
- a one-cycle pulse on its own interrupt line;
- a level held in a status bit until software clears it;
- a message write of a programmed data word to a programmed address, placed on a single message output.

A legacy routing switch redirects channel 0 to the tick output and channel 1 to the RTC output. While the switch is set, those two channels stay off their own lines and off the message path.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter reads 0, every interrupt, legacy and message output is low, and each channel configuration reads only its constant capability bits (0x8030 for channels 0 and 1).
- R2: The counter advances by one per clock only while bit 0 of the general configuration at byte offset 0x010 is set. While stopped it holds its value. Its low half is written and read at offset 0x0F0 and its high half at offset 0x0F4.
- R3: Offset 0x000 returns the channel count minus one in bits 12:8 and a legacy-capable flag in bit 15, which gives 0x8200 for three channels. Offset 0x004 returns the tick period in femtoseconds (5000000 by default).
- R4: Channel n has its registers at byte offset 0x100 + 0x20*n: configuration at +0x00, comparator at +0x08, message data at +0x10, message address at +0x14. In the configuration register, bit 2 is enable and bit 1 selects level mode. When the counter is started from value S by the write at edge E0, a one-shot edge channel with comparator M pulses its line for exactly one cycle after edge E0+((M-S) mod 2^32)+1. The comparator keeps the value M afterwards.
- R5: A periodic channel (configuration bit 3) adds its period to the comparator on each match, so successive pulses are one period apart.
- R6: Writing the configuration with bit 6 (set-value) set arms a two-step sequence. The next comparator write loads the comparator and the write after that loads the period. Bit 6 always reads as 0.
- R7: Channel 2 has no periodic capability. Its bit 3 is ignored on write and its bit 4 reads 0. Channels 0 and 1 report bit 4 as 1. All channels report bit 5 (32-bit) and bit 15 (message capable) as 1.
- R8: Matching uses only the low 32 bits of the counter, so a comparator below the start value matches after the low half wraps past zero. The wrap carries into the high half.
- R9: A level-mode channel sets bit n of the status register at 0x020 on a match. The bit drives its line until software writes 1 to that bit.
- R10: With bit 1 of the general configuration set, channel 0 events appear on the legacy tick output and channel 1 events on the legacy RTC output. Their own lines stay low.
- R11: With configuration bit 14 set, a match produces no line event. Instead, one cycle after the line timing of R4, the message output presents a one-cycle valid with that channel's data and address. If several messages are due in the same cycle, the lowest channel index goes first and the others follow on later cycles.
- R12: A channel whose enable bit is clear produces no event even when its comparator equals the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_ren |
| irq_line | output | 3 | Per-channel interrupt lines |
| legacy_tick | output | 1 | Legacy tick interrupt (channel 0 when routed) |
| legacy_rtc | output | 1 | Legacy RTC interrupt (channel 1 when routed) |
| msg_valid | output | 1 | Message write strobe |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
On every cycle the assertions check the following local rules: a stopped counter holds still, a periodic match adds exactly the stored period, a one-shot match leaves the comparator alone, a write-one-clear empties the status bits it names, and the message output stays quiet when nothing is pending. Only the bench scenarios can show the end-to-end cycle at which each line, legacy output or message appears relative to the start of counting. The same holds for the ordering of the set-value write pair, the wrap on the low half, and the priority between simultaneous messages, because those depend on register sequences across many cycles.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CFG_LVL   = 1;
  localparam int CFG_EN    = 2;
  localparam int CFG_PER   = 3;
  localparam int CFG_PCAP  = 4;
  localparam int CFG_W32   = 5;
  localparam int CFG_SETV  = 6;
  localparam int CFG_MSGEN = 14;
  localparam int CFG_MCAP  = 15;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CMP  = 2'd1,
    SEQ_PER  = 2'd2
  } seq_e;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0] count
);
  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) count[HALF-1:0]     <= wdata;
      if (wr_hi) count[CNT_W-1:HALF] <= wdata;
    end else if (run) begin
      count <= count + 1'b1;
    end
  end

  // R2: stopped counter keeps its value
  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_lo && !wr_hi) |=> $stable(count));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter bit PER_CAP = 1'b1,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] cnt_lo,
  input  logic          cfg_we,
  input  logic          cmp_we,
  input  logic          data_we,
  input  logic          addr_we,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic          lvl_mode,
  output logic          msg_mode,
  output logic [DW-1:0] cfg_rd,
  output logic [DW-1:0] cmp_rd,
  output logic [DW-1:0] msg_data,
  output logic [DW-1:0] msg_addr
);
  logic          en, per;
  logic [DW-1:0] cmp, period;
  seq_e          seq;

  assign hit      = en && run && (cnt_lo == cmp);
  assign cmp_rd   = cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; per <= 1'b0; lvl_mode <= 1'b0; msg_mode <= 1'b0;
      cmp <= '0; period <= '0; seq <= SEQ_IDLE;
      msg_data <= '0; msg_addr <= '0;
    end else begin
      if (cfg_we) begin
        en       <= wdata[CFG_EN];
        per      <= PER_CAP && wdata[CFG_PER];
        lvl_mode <= wdata[CFG_LVL];
        msg_mode <= wdata[CFG_MSGEN];
        if (wdata[CFG_SETV]) seq <= SEQ_CMP;
      end
      if (cmp_we) begin
        case (seq)
          SEQ_CMP: begin cmp <= wdata;    seq <= SEQ_PER;  end
          SEQ_PER: begin period <= wdata; seq <= SEQ_IDLE; end
          default: cmp <= wdata;
        endcase
      end else if (hit && per) begin
        cmp <= cmp + period;
      end
      if (data_we) msg_data <= wdata;
      if (addr_we) msg_addr <= wdata;
    end
  end

  always_comb begin
    cfg_rd            = '0;
    cfg_rd[CFG_LVL]   = lvl_mode;
    cfg_rd[CFG_EN]    = en;
    cfg_rd[CFG_PER]   = per;
    cfg_rd[CFG_PCAP]  = PER_CAP;
    cfg_rd[CFG_W32]   = 1'b1;
    cfg_rd[CFG_MSGEN] = msg_mode;
    cfg_rd[CFG_MCAP]  = 1'b1;
  end

  // R5: periodic match advances the comparator by the period
  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && per && !cmp_we) |=> (cmp == $past(cmp) + $past(period)));
  // R4: one-shot match leaves the comparator untouched
  assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !per && !cmp_we) |=> $stable(cmp));
endmodule

// File: rtl/evt_msg_arb.sv
module evt_msg_arb #(
  parameter int NCH = 3,
  parameter int DW  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          req,
  input  logic [NCH-1:0][DW-1:0]  data_in,
  input  logic [NCH-1:0][DW-1:0]  addr_in,
  output logic                    valid,
  output logic [DW-1:0]           data,
  output logic [DW-1:0]           addr
);
  logic [NCH-1:0] pend, grant;
  logic [DW-1:0]  sel_data, sel_addr;
  logic           found;

  always_comb begin
    grant    = '0;
    found    = 1'b0;
    sel_data = '0;
    sel_addr = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pend[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        sel_data = data_in[i];
        sel_addr = addr_in[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0; valid <= 1'b0; data <= '0; addr <= '0;
    end else begin
      pend  <= (pend & ~grant) | req;
      valid <= found;
      data  <= sel_data;
      addr  <= sel_addr;
    end
  end

  // R11: no message leaves when nothing was pending or requested
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (pend == '0 && req == '0) |=> !valid);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int NPER      = 2,
  parameter int PERIOD_FS = 5000000,
  parameter int AW        = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wen,
  input  logic           reg_ren,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           reg_rvalid,
  output logic [NCH-1:0] irq_line,
  output logic           legacy_tick,
  output logic           legacy_rtc,
  output logic           msg_valid,
  output logic [31:0]    msg_addr,
  output logic [31:0]    msg_data
);
  localparam int DW = 32;
  localparam int IW = AW - 5;
  localparam logic [AW-1:0] A_ID  = AW'(12'h000);
  localparam logic [AW-1:0] A_PER = AW'(12'h004);
  localparam logic [AW-1:0] A_GEN = AW'(12'h010);
  localparam logic [AW-1:0] A_STS = AW'(12'h020);
  localparam logic [AW-1:0] A_CLO = AW'(12'h0F0);
  localparam logic [AW-1:0] A_CHI = AW'(12'h0F4);
  localparam logic [AW-1:0] A_CH  = AW'(12'h100);
  localparam logic [NCH-1:0] LEG_MASK = NCH'(3);
  localparam logic [31:0] ID_VAL = (32'(NCH - 1) << 8) | 32'h8000;

  logic           run, legacy;
  logic [63:0]    count;
  logic [NCH-1:0] status, edge_q, hit, lvl_m, msg_m, deliv, leg_sel, line;
  logic [NCH-1:0][DW-1:0] cfg_rd, cmp_rd, ch_data, ch_addr;
  logic [AW-1:0]  ch_rel;
  logic [IW-1:0]  ch_idx;
  logic [4:0]     ch_off;
  logic           in_ch;
  logic [31:0]    rd_next;
  logic           sts_we;

  assign ch_rel = reg_addr - A_CH;
  assign ch_idx = ch_rel[AW-1:5];
  assign ch_off = ch_rel[4:0];
  assign in_ch  = (reg_addr >= A_CH) && (int'(ch_idx) < NCH);
  assign sts_we = reg_wen && (reg_addr == A_STS);

  evt_main_counter #(.CNT_W(64)) u_cnt (
    .clk(clk), .rst(rst), .run(run),
    .wr_lo(reg_wen && reg_addr == A_CLO),
    .wr_hi(reg_wen && reg_addr == A_CHI),
    .wdata(reg_wdata), .count(count)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = reg_wen && in_ch && (ch_idx == IW'(i));
    evt_channel #(.PER_CAP(i < NPER), .DW(DW)) u_ch (
      .clk(clk), .rst(rst), .run(run), .cnt_lo(count[31:0]),
      .cfg_we(sel && ch_off == 5'h00), .cmp_we(sel && ch_off == 5'h08),
      .data_we(sel && ch_off == 5'h10), .addr_we(sel && ch_off == 5'h14),
      .wdata(reg_wdata), .hit(hit[i]), .lvl_mode(lvl_m[i]), .msg_mode(msg_m[i]),
      .cfg_rd(cfg_rd[i]), .cmp_rd(cmp_rd[i]),
      .msg_data(ch_data[i]), .msg_addr(ch_addr[i])
    );
  end

  assign leg_sel = legacy ? LEG_MASK : '0;
  assign deliv   = msg_m & ~leg_sel;
  assign line    = status | edge_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; legacy <= 1'b0; status <= '0; edge_q <= '0;
    end else begin
      if (reg_wen && reg_addr == A_GEN) begin
        run    <= reg_wdata[0];
        legacy <= reg_wdata[1];
      end
      status <= (status & ~(sts_we ? reg_wdata[NCH-1:0] : '0)) | (hit & lvl_m & ~deliv);
      edge_q <= hit & ~lvl_m & ~deliv;
    end
  end

  assign irq_line    = line & ~leg_sel;
  assign legacy_tick = legacy & line[0];
  assign legacy_rtc  = legacy & line[1];

  evt_msg_arb #(.NCH(NCH), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .req(hit & deliv),
    .data_in(ch_data), .addr_in(ch_addr),
    .valid(msg_valid), .data(msg_data), .addr(msg_addr)
  );

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      A_ID:    rd_next = ID_VAL;
      A_PER:   rd_next = 32'(PERIOD_FS);
      A_GEN:   rd_next = {30'd0, legacy, run};
      A_STS:   rd_next = 32'(status);
      A_CLO:   rd_next = count[31:0];
      A_CHI:   rd_next = count[63:32];
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (in_ch && ch_idx == IW'(i)) begin
            case (ch_off)
              5'h00:   rd_next = cfg_rd[i];
              5'h08:   rd_next = cmp_rd[i];
              5'h10:   rd_next = ch_data[i];
              5'h14:   rd_next = ch_addr[i];
              default: rd_next = '0;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0; reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_ren;
      if (reg_ren) reg_rdata <= rd_next;
    end
  end

  // R9: a write of ones clears those status bits when no new match lands
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (sts_we && ((reg_wdata[NCH-1:0] & hit) == '0)) |=>
      ((status & $past(reg_wdata[NCH-1:0])) == '0));
endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
  localparam int NCH = 3;
  localparam logic [11:0] GEN = 12'h010, STS = 12'h020, CLO = 12'h0F0, CHI = 12'h0F4;
  localparam int NV = 5;
  localparam int VCH  [NV] = '{0, 1, 2, 2, 1};
  localparam int VCMP [NV] = '{5, 12, 3, 0, 40};
  localparam int VEXP [NV] = '{6, 13, 4, 1, 41};

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wen = 1'b0, reg_ren = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, msg_addr, msg_data;
  logic reg_rvalid, legacy_tick, legacy_rtc, msg_valid;
  logic [NCH-1:0] irq_line;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer dut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq_line(irq_line), .legacy_tick(legacy_tick), .legacy_rtc(legacy_rtc),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] cha(input int ch, input int off);
    return 12'(256 + 32 * ch + off);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_ren = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0, 1, 2: return irq_line[sel];
      3:       return legacy_tick;
      4:       return legacy_rtc;
      default: return msg_valid;
    endcase
  endfunction

  task automatic waitsig(input int sel, input int lim, output int n);
    n = 0;
    while (!sig(sel) && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic prep();
    wr(GEN, 0); wr(CLO, 0); wr(CHI, 0);
    for (int c = 0; c < NCH; c++) wr(cha(c, 0), 0);
    wr(STS, 32'h7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int n, m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 32'(irq_line), 0);
    chk("R1 msg", 32'(msg_valid), 0);
    chk("R1 legacy", 32'({legacy_tick, legacy_rtc}), 0);
    rd(CLO, d); chk("R1 counter", d, 0);
    rd(cha(0, 0), d); chk("R1 cfg0", d, 32'h8030);
    // R3 identity and period
    rd(12'h000, d); chk("R3 id", d, 32'h8200);
    rd(12'h004, d); chk("R3 period", d, 32'd5000000);
    // R7 capability bits
    wr(cha(2, 0), 32'h0C); rd(cha(2, 0), d); chk("R7 ch2 cfg", d, 32'h8024);
    wr(cha(0, 0), 32'h0C); rd(cha(0, 0), d); chk("R7 ch0 cfg", d, 32'h803C);
    // R2 counter stop/run and halves
    prep();
    wr(CLO, 32'h55);
    rd(CLO, d); rd(CLO, d2);
    chk("R2 stopped a", d, 32'h55); chk("R2 stopped b", d2, 32'h55);
    wr(CHI, 32'h9); rd(CHI, d); chk("R2 high half", d, 32'h9);
    wr(GEN, 1); rd(CLO, d); rd(CLO, d2);
    chk("R2 running step", d2 - d, 1);
    // R4 one-shot edge table
    for (int v = 0; v < NV; v++) begin
      prep();
      wr(cha(VCH[v], 8), 32'(VCMP[v]));
      wr(cha(VCH[v], 0), 32'h4);
      wr(GEN, 1);
      waitsig(VCH[v], 200, n);
      chk("R4 delay", 32'(n), 32'(VEXP[v]));
      @(negedge clk);
      chk("R4 one-cycle pulse", 32'(irq_line[VCH[v]]), 0);
      rd(cha(VCH[v], 8), d);
      chk("R4 cmp unchanged", d, 32'(VCMP[v]));
    end
    // R6 and R5 set-value sequence and periodic reload
    prep();
    wr(cha(0, 0), 32'h4C); wr(cha(0, 8), 10); wr(cha(0, 8), 20);
    rd(cha(0, 0), d); chk("R6 setval reads 0", d & 32'h40, 0);
    wr(GEN, 1);
    waitsig(0, 200, n); chk("R6 first match", 32'(n), 11);
    @(negedge clk);
    waitsig(0, 200, m); chk("R5 period gap", 32'(m + 12), 31);
    // R8 wrap on low half
    prep();
    wr(CLO, 32'hFFFF_FFFE); wr(cha(0, 8), 1); wr(cha(0, 0), 32'h4);
    wr(GEN, 1);
    waitsig(0, 200, n); chk("R8 wrap match", 32'(n), 4);
    rd(CHI, d); chk("R8 carry", d, 1);
    // R9 level mode
    prep();
    wr(cha(1, 8), 4); wr(cha(1, 0), 32'h6); wr(GEN, 1);
    waitsig(1, 200, n); chk("R9 level delay", 32'(n), 5);
    repeat (3) @(negedge clk);
    chk("R9 held", 32'(irq_line[1]), 1);
    rd(STS, d); chk("R9 status", d, 2);
    wr(STS, 2); chk("R9 cleared", 32'(irq_line[1]), 0);
    // R10 legacy routing
    prep();
    wr(cha(0, 8), 6); wr(cha(0, 0), 32'h4); wr(GEN, 3);
    waitsig(3, 200, n); chk("R10 tick delay", 32'(n), 7);
    chk("R10 own line low", 32'(irq_line[0]), 0);
    prep();
    wr(cha(1, 8), 3); wr(cha(1, 0), 32'h4); wr(GEN, 3);
    waitsig(4, 200, n); chk("R10 rtc delay", 32'(n), 4);
    chk("R10 own line1 low", 32'(irq_line[1]), 0);
    // R11 message delivery and priority
    prep();
    wr(cha(2, 16), 32'hABCD); wr(cha(2, 20), 32'h1000);
    wr(cha(2, 8), 5); wr(cha(2, 0), 32'h4004); wr(GEN, 1);
    waitsig(5, 200, n); chk("R11 msg delay", 32'(n), 7);
    chk("R11 data", msg_data, 32'hABCD); chk("R11 addr", msg_addr, 32'h1000);
    chk("R11 no line", 32'(irq_line[2]), 0);
    prep();
    wr(cha(0, 16), 32'hA0); wr(cha(0, 20), 32'h2000); wr(cha(0, 8), 4); wr(cha(0, 0), 32'h4004);
    wr(cha(2, 16), 32'hB2); wr(cha(2, 20), 32'h3000); wr(cha(2, 8), 4); wr(cha(2, 0), 32'h4004);
    wr(GEN, 1);
    waitsig(5, 200, n); chk("R11 pair delay", 32'(n), 6);
    chk("R11 first is ch0", msg_data, 32'hA0);
    @(negedge clk);
    chk("R11 second valid", 32'(msg_valid), 1);
    chk("R11 second is ch2", msg_data, 32'hB2);
    chk("R11 second addr", msg_addr, 32'h3000);
    // R12 disabled channel
    prep();
    wr(cha(0, 8), 2); wr(cha(0, 0), 32'h0); wr(GEN, 1);
    waitsig(0, 10, n); chk("R12 no event", 32'(n), 10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule